// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a running calendar, given as seven BCD fields (seconds, minutes, hours, weekday, day of month, month and year), and raises an alarm when that calendar reaches a programmed instant. Every alarm field has its own enable flag, so an alarm can be made to ignore any subset of fields. A common case is an alarm on a full date and time that leaves the weekday out.

Software writes each alarm field into a staging register. The staged set only becomes the active alarm when a commit word is written, so a half-updated alarm is never compared. The comparison runs once per one-second tick, which the calendar counter raises in the cycle its new time is valid. A match sets a sticky status flag, and software clears that flag by writing one to it. An interrupt line shows the status flag, gated by an interrupt-enable bit. The calendar counter is not part of this block.

Top module: `calendar_alarm`

## Requirements
- R1: Register addresses 0 to 6 hold the alarm fields in this order: seconds (7 bits), minutes (7), hours (6), weekday (3), day (6), month (5) and year (8). A write keeps data bit 15 as the field enable and the low field-width bits as the value. Reading one of these addresses returns the committed field as {enable, 7'b0, value zero-extended to 8 bits}.
- R2: Writes to addresses 0 to 6 change only the staged copy. The active alarm (readback and comparison) takes the staged values only when address 7 is written with data bit 15 set. A write to address 7 with bit 15 clear has no effect.
- R3: Address 8 bit 0 is the interrupt enable and reads back in bit 0. Address 9 bit 0 is the status flag and reads back in bit 0. Every other address reads as zero.
- R4: A match is evaluated only in a cycle with tick_i high. Equal fields without a tick never set the status.
- R5: A match requires every enabled field to equal its time input. A field with its enable clear is ignored, for example the weekday in an otherwise fully enabled alarm.
- R6: When no field is enabled, no match ever occurs.
- R7: A match sets the status flag on the next clock edge whatever the interrupt enable is. The flag then stays set until it is cleared.
- R8: Writing address 9 with data bit 0 set clears the status flag. Writing it with bit 0 clear leaves the flag unchanged.
- R9: irq_o is high exactly when the status flag and the interrupt enable are both set.
- R10: When a match and a clear write to address 9 fall in the same cycle, the status flag ends up set.
- R11: After reset, all staged and active fields, the enable and the status are zero, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe; time inputs are valid in this cycle |
| time_sec_i | input | 7 | Current seconds, BCD |
| time_min_i | input | 7 | Current minutes, BCD |
| time_hour_i | input | 6 | Current hours, BCD |
| time_wday_i | input | 3 | Current weekday |
| time_day_i | input | 6 | Current day of month, BCD |
| time_mon_i | input | 5 | Current month, BCD |
| time_year_i | input | 8 | Current year, BCD |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 16 | Register read data, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Random alarms with random enable masks are compared against times that copy most fields and perturb some. A single differing enabled field must block the match, while a differing disabled field must not. Masks with the weekday left out, the empty mask and the all-enabled mask are forced, to separate the ignore rule from the no-field rule. Directed cases cover equal times without a tick, a staged change without commit and a commit with its trigger bit clear. They also cover a write of zero to the status, a clear that coincides with a match, and the interrupt with its enable both on and off.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned NUM_FIELDS  = 7;
  localparam int unsigned FIELD_MAX_W = 8;
  localparam int unsigned ADDR_COMMIT = 7;
  localparam int unsigned ADDR_IRQ_EN = 8;
  localparam int unsigned ADDR_STATUS = 9;

  typedef struct packed {
    logic                   en;
    logic [FIELD_MAX_W-1:0] val;
  } alarm_field_t;

  // BCD width of each field, index order sec, min, hour, wday, day, mon, year
  function automatic int unsigned field_width(int unsigned idx);
    case (idx)
      0, 1:    return 7;
      2, 4:    return 6;
      3:       return 3;
      5:       return 5;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output alarm_field_t [NUM_FIELDS-1:0]  active_o
);
  localparam int unsigned EN_BIT = DATA_W - 1;

  alarm_field_t [NUM_FIELDS-1:0] staged_q;
  alarm_field_t [NUM_FIELDS-1:0] active_q;
  logic commit;

  assign commit = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_COMMIT)) && wr_data_i[EN_BIT];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_slot
    localparam int unsigned W = field_width(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        staged_q[g] <= '0;
      end else if (wr_en_i && (wr_addr_i == ADDR_W'(g))) begin
        staged_q[g].en  <= wr_data_i[EN_BIT];
        staged_q[g].val <= FIELD_MAX_W'(wr_data_i[W-1:0]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= '0;
    else if (commit) active_q <= staged_q;
  end

  assign active_o = active_q;

  // R2: any write that is not to the commit address leaves the active alarm alone
  a_r2_no_commit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != ADDR_W'(ADDR_COMMIT)) |=> $stable(active_o));
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  tick_i,
  input  alarm_field_t [NUM_FIELDS-1:0]         active_i,
  input  logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] now_i,
  output logic                                  hit_o
);
  logic [NUM_FIELDS-1:0] en_vec;
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    localparam int unsigned W = field_width(g);
    assign en_vec[g]   = active_i[g].en;
    assign field_ok[g] = !active_i[g].en || (active_i[g].val[W-1:0] == now_i[g][W-1:0]);
  end

  assign hit_o = tick_i && (|en_vec) && (&field_ok);

  // R4: no match outside a tick
  a_r4_hit_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> tick_i);
  // R6: a match needs at least one enabled field
  a_r6_hit_needs_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($countones(en_vec) != 0));
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic ie_wr_i,
  input  logic ie_val_i,
  input  logic clr_i,
  output logic ie_o,
  output logic status_o,
  output logic irq_o
);
  logic ie_q, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ie_q <= 1'b0;
    else if (ie_wr_i) ie_q <= ie_val_i;
  end

  // set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_q <= 1'b0;
    else if (hit_i) status_q <= 1'b1;
    else if (clr_i) status_q <= 1'b0;
  end

  assign ie_o     = ie_q;
  assign status_o = status_q;
  assign irq_o    = status_q & ie_q;

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !clr_i) |=> status_o);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !status_o);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> status_o);
  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_wr_i && !ie_val_i) |=> !irq_o);
endmodule

// File: rtl/calendar_alarm.sv
module calendar_alarm
  import cal_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [6:0]        time_sec_i,
  input  logic [6:0]        time_min_i,
  input  logic [5:0]        time_hour_i,
  input  logic [2:0]        time_wday_i,
  input  logic [5:0]        time_day_i,
  input  logic [4:0]        time_mon_i,
  input  logic [7:0]        time_year_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned EN_BIT = DATA_W - 1;

  alarm_field_t [NUM_FIELDS-1:0]           active;
  logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0]  now_time;
  logic hit, ie, status, ie_wr, clr;

  assign now_time[0] = FIELD_MAX_W'(time_sec_i);
  assign now_time[1] = FIELD_MAX_W'(time_min_i);
  assign now_time[2] = FIELD_MAX_W'(time_hour_i);
  assign now_time[3] = FIELD_MAX_W'(time_wday_i);
  assign now_time[4] = FIELD_MAX_W'(time_day_i);
  assign now_time[5] = FIELD_MAX_W'(time_mon_i);
  assign now_time[6] = time_year_i;

  assign ie_wr = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_IRQ_EN));
  assign clr   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_STATUS)) && wr_data_i[0];

  cal_alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .active_o (active)
  );

  cal_alarm_match u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .active_i(active),
    .now_i   (now_time),
    .hit_o   (hit)
  );

  cal_alarm_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .ie_wr_i (ie_wr),
    .ie_val_i(wr_data_i[0]),
    .clr_i   (clr),
    .ie_o    (ie),
    .status_o(status),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rd_addr_i == ADDR_W'(i)) begin
        rd_data_o[EN_BIT]          = active[i].en;
        rd_data_o[FIELD_MAX_W-1:0] = active[i].val;
      end
    end
    if (rd_addr_i == ADDR_W'(ADDR_IRQ_EN)) rd_data_o[0] = ie;
    if (rd_addr_i == ADDR_W'(ADDR_STATUS)) rd_data_o[0] = status;
  end

  // R9: the interrupt is never raised while the enable is clear
  a_r9_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie);
endmodule

// File: tb/calendar_alarm_tb.sv
`timescale 1ns/1ps
module calendar_alarm_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [6:0] t_sec = '0, t_min = '0;
  logic [5:0] t_hour = '0, t_day = '0;
  logic [2:0] t_wday = '0;
  logic [4:0] t_mon = '0;
  logic [7:0] t_year = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] st_val[7], ac_val[7], tm[7];
  bit st_en[7], ac_en[7];
  bit m_ie = 0, m_st = 0;

  always #2.5 clk = ~clk;

  calendar_alarm u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .time_sec_i(t_sec), .time_min_i(t_min), .time_hour_i(t_hour),
    .time_wday_i(t_wday), .time_day_i(t_day), .time_mon_i(t_mon),
    .time_year_i(t_year), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic int fw(int i);
    case (i)
      0, 1: return 7;
      2, 4: return 6;
      3: return 3;
      5: return 5;
      default: return 8;
    endcase
  endfunction

  function automatic logic [7:0] fmask(int i);
    return 8'((16'd1 << fw(i)) - 1);
  endfunction

  function automatic logic [15:0] exp_read(int a);
    if (a < 7) return {ac_en[a], 7'b0, ac_val[a]};
    if (a == 8) return {15'b0, m_ie};
    if (a == 9) return {15'b0, m_st};
    return 16'h0;
  endfunction

  function automatic bit exp_match();
    bit any = 0, ok = 1;
    for (int i = 0; i < 7; i++)
      if (ac_en[i]) begin
        any = 1;
        if ((tm[i] & fmask(i)) != ac_val[i]) ok = 0;
      end
    return any && ok;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_wr(int a, logic [15:0] d);
    if (a < 7) begin st_en[a] = d[15]; st_val[a] = d[7:0] & fmask(a); end
    else if (a == 7 && d[15]) begin ac_en = st_en; ac_val = st_val; end
    else if (a == 8) m_ie = d[0];
    else if (a == 9 && d[0]) m_st = 0;
  endtask

  task automatic do_wr(int a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(string req, int a);
    rd_addr = 4'(a);
    #0.5;
    chk(req, rd_data, exp_read(a));
  endtask

  task automatic drive_time();
    t_sec = tm[0][6:0]; t_min = tm[1][6:0]; t_hour = tm[2][5:0];
    t_wday = tm[3][2:0]; t_day = tm[4][5:0]; t_mon = tm[5][4:0]; t_year = tm[6];
  endtask

  // one tick, optionally with a same-cycle status clear
  task automatic do_tick(bit with_clr, bit tick_on);
    bit h;
    @(negedge clk);
    drive_time();
    tick = tick_on;
    if (with_clr) begin wr_en = 1; wr_addr = 4'd9; wr_data = 16'h0001; end
    h = tick_on && exp_match();
    @(negedge clk);
    tick = 0; wr_en = 0;
    if (with_clr) m_st = 0;
    if (h) m_st = 1;
  endtask

  task automatic chk_irq(string req);
    #0.5;
    chk(req, {15'b0, irq}, {15'b0, m_st & m_ie});
  endtask

  task automatic load_alarm(logic [6:0] en, bit commit);
    for (int i = 0; i < 7; i++) do_wr(i, {en[i], 7'($urandom), 8'($urandom)});
    if (commit) do_wr(7, 16'h8000);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 7; i++) begin st_val[i] = 0; ac_val[i] = 0; st_en[i] = 0; ac_en[i] = 0; tm[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    for (int a = 0; a < 16; a++) rd_chk("R11 reset readback", a);
    chk_irq("R11 reset irq");

    // R6: reset alarm with zero enables must not match even at equal time
    do_tick(0, 1);
    rd_chk("R6 no field enabled", 9);

    // R1/R2: staged write is invisible until commit
    do_wr(0, 16'h80FF);
    rd_chk("R2 staged not active", 0);
    do_wr(7, 16'h0000);
    rd_chk("R2 commit without trigger bit", 0);
    do_wr(7, 16'h8000);
    rd_chk("R1 field mask sec", 0);
    do_wr(3, 16'hFFFF); do_wr(5, 16'h7FFF); do_wr(7, 16'h8000);
    rd_chk("R1 field mask wday", 3);
    rd_chk("R1 field mask mon", 5);
    rd_chk("R3 unused address", 12);

    // R4: equal time without tick
    for (int i = 0; i < 7; i++) tm[i] = ac_val[i];
    do_tick(0, 0);
    rd_chk("R4 no tick no match", 9);
    do_tick(0, 1);
    rd_chk("R4 tick match", 9);
    chk_irq("R9 irq off while enable clear");

    // R9 enable
    do_wr(8, 16'h0001);
    rd_chk("R3 ie readback", 8);
    chk_irq("R9 irq on");
    // R8 write zero has no effect, then clear
    do_wr(9, 16'h0000);
    rd_chk("R8 write zero keeps status", 9);
    do_wr(9, 16'h0001);
    rd_chk("R8 w1c", 9);
    chk_irq("R9 irq after clear");

    // R10 set and clear in same cycle
    do_tick(1, 1);
    rd_chk("R10 set wins", 9);
    do_tick(1, 0);
    rd_chk("R8 clear without match", 9);

    // R5 weekday excluded
    load_alarm(7'b1110111, 1);
    for (int i = 0; i < 7; i++) tm[i] = ac_val[i];
    tm[3] = ac_val[3] ^ 8'h5;
    do_tick(0, 1);
    rd_chk("R5 weekday ignored", 9);
    tm[3] = ac_val[3];
    tm[4] = ac_val[4] ^ 8'h1;
    do_wr(9, 16'h0001);
    do_tick(0, 1);
    rd_chk("R5 enabled day mismatch", 9);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [6:0] en;
      int sel = $urandom_range(0, 9);
      en = (sel == 0) ? 7'h00 : (sel == 1) ? 7'h7F : (sel == 2) ? 7'b1110111 : 7'($urandom);
      load_alarm(en, 1);
      rd_chk("R1 random readback", $urandom_range(0, 6));
      do_wr(9, 16'h0001);
      do_wr(8, {15'b0, 1'($urandom)});
      for (int i = 0; i < 7; i++)
        tm[i] = ($urandom_range(0, 3) != 0) ? ac_val[i] : 8'($urandom);
      do_tick(0, 1);
      rd_chk("R5 R7 random match status", 9);
      chk_irq("R9 random irq");
      if ($urandom_range(0, 1) == 1) begin
        load_alarm(7'($urandom), 0);
        rd_chk("R2 random staged hold", $urandom_range(0, 6));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule